// File: doc/BRIEF.md
# SCSI Initiator Register Front End

This block is the byte-wide, memory-mapped register face of a simple SCSI initiator controller. A CPU reaches it through one address bus, one write-data bus and separate read and write strobes. The block turns each address into one of sixteen register slots spaced four bytes apart. It keeps two banks of registers: one holds the last value the CPU wrote to each slot, and the other holds what the CPU reads back. It also decodes bytes written to the command slot into actions.

Decoded actions either update the interrupt, sequence-step and status registers directly or leave the block as one-clock pulses toward a transfer engine. The pulses are start transfer, select with attention, select with attention and stop, and status/message response. In the other direction, the transfer engine posts its results on a report strobe, which loads status, interrupt and sequence-step together and raises the interrupt line. The interrupt line is a registered level. The CPU acknowledges it by reading the interrupt register, and that read also clears the error and interrupt flags in the status register.

Top module: `scsi_reg_front`

## Requirements
- R1: The slot index is (address AND 0x3F) shifted right by two. A read strobe places the addressed readable slot on `bus_rdata` one clock later, and the value shown is the one held before that read's own side effects. `bus_rdata` holds its value between reads.
- R2: After reset every readable slot is 0x00 except slot 14, which reads 0x04; `irq` and `dma_mode` are low and no action pulse is high.
- R3: A write to slot 3 makes slot 3 read back the written byte. If bit 7 of the byte is set, `dma_mode` goes high and slots 0 and 1 read back the bytes last written to slots 0 and 1. If bit 7 is clear, `dma_mode` goes low and slots 0 and 1 keep their readable values.
- R4: Command codes, taken from the low 7 bits of the byte, raise one pulse each for exactly one clock, in the clock after the write: 0x10 gives `xfer_start`, 0x42 gives `sel_atn`, 0x43 gives `sel_atn_stop`, and both 0x11 and 0x12 give `resp_start`.
- R5: Command 0x01 (FIFO flush) sets slot 5 to 0x08 and slot 6 to 0x00.
- R6: Command 0x12 (message accepted) sets slot 5 to 0x20 and slot 6 to 0x00.
- R7: Command 0x03 (bus reset) sets slot 5 to 0x80. It raises `irq` only if bit 6 of the last byte written to slot 8 is 0.
- R8: A read of slot 5 clears bits 7, 6 and 5 of slot 4 and drops `irq`.
- R9: A write to slot 0 or slot 1 clears bit 4 of slot 4, and it does not change the readable value of slots 0 and 1.
- R10: Writes to slot 8 and to slots 12 to 15 are stored as written. A write to slot 11 stores only the bits in 0x15. Writes to slots 2, 4, 5, 6, 7, 9 and 10 leave their readable values unchanged.
- R11: Command 0x02 (chip reset) returns all readable slots, `dma_mode` and `irq` to their reset values. It also clears every stored write value, so a following DMA command loads 0x00 into slots 0 and 1.
- R12: A report strobe loads slots 4, 5 and 6 from `eng_status`, `eng_intr` and `eng_seq` and raises `irq`. If a read of slot 5 or a write to slot 0 or 1 falls in the same cycle, the reported values and the raised `irq` win.
- R13: Any other command code changes only slot 3 and `dma_mode`. It fires no pulse and leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe, one access per clock |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request level |
| dma_mode | output | 1 | High while DMA mode is selected |
| xfer_start | output | 1 | One-clock pulse: start information transfer |
| sel_atn | output | 1 | One-clock pulse: select with attention |
| sel_atn_stop | output | 1 | One-clock pulse: select with attention and stop |
| resp_start | output | 1 | One-clock pulse: status/message response |
| eng_report | input | 1 | Transfer-engine result strobe |
| eng_status | input | DATA_W | Reported status byte |
| eng_intr | input | DATA_W | Reported interrupt byte |
| eng_seq | input | DATA_W | Reported sequence-step byte |

## Verification
The two functions that can land in the same clock are the CPU's interrupt acknowledge, a read of slot 5, and an engine report, which loads the status registers and raises the interrupt. The bench drives the report strobe in the same cycle as a slot 5 read. It then requires that the read returns the old interrupt byte, that `irq` stays high, and that slot 4 holds the freshly reported status with none of its bits cleared. A second collision pairs a report with a write to a transfer-count slot, and there the reported terminal-count bit must survive.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;

    // Fixed slot indices (the behaviour of each slot depends on its index)
    localparam int SLOT_TC_LO   = 0;
    localparam int SLOT_TC_HI   = 1;
    localparam int SLOT_CMD     = 3;
    localparam int SLOT_STAT    = 4;
    localparam int SLOT_INTR    = 5;
    localparam int SLOT_SEQ     = 6;
    localparam int SLOT_CFG     = 8;
    localparam int SLOT_MASKED  = 11;
    localparam int SLOT_DIR_LO  = 12;
    localparam int SLOT_VARIANT = 14;

    // Bit positions and byte codes
    localparam int CMD_DMA_BIT    = 7;
    localparam int CFG_BRST_QUIET = 6;

    localparam logic [7:0] VARIANT_ID     = 8'h04;
    localparam logic [7:0] MASK_SLOT11    = 8'h15;
    localparam logic [7:0] STAT_TC        = 8'h10;
    localparam logic [7:0] STAT_ACK_CLR   = 8'hE0;
    localparam logic [7:0] INTR_FUNC_DONE = 8'h08;
    localparam logic [7:0] INTR_DISCON    = 8'h20;
    localparam logic [7:0] INTR_BUS_RST   = 8'h80;

    typedef enum logic [3:0] {
        CK_NOP,
        CK_FLUSH,
        CK_CHIPRST,
        CK_BUSRST,
        CK_XFER,
        CK_CMPLSEQ,
        CK_MSGACC,
        CK_SELATN,
        CK_SELSTOP,
        CK_UNKNOWN
    } cmd_kind_t;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_t;

endpackage

// File: rtl/scsi_fe_addr_dec.sv
module scsi_fe_addr_dec #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    // Slots sit on four-byte strides; the upper address bits alias.
    localparam int HI_BIT = IDX_W + 1;

    always_comb begin
        idx = addr[HI_BIT:2];
    end
endmodule

// File: rtl/scsi_fe_cmd_dec.sv
module scsi_fe_cmd_dec #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]          cmd,
    output scsi_fe_pkg::cmd_kind_t     kind,
    output logic                       dma_sel
);
    import scsi_fe_pkg::*;

    always_comb begin
        dma_sel = cmd[CMD_DMA_BIT];
        unique case (cmd[6:0])
            7'h00:   kind = CK_NOP;
            7'h01:   kind = CK_FLUSH;
            7'h02:   kind = CK_CHIPRST;
            7'h03:   kind = CK_BUSRST;
            7'h10:   kind = CK_XFER;
            7'h11:   kind = CK_CMPLSEQ;
            7'h12:   kind = CK_MSGACC;
            7'h42:   kind = CK_SELATN;
            7'h43:   kind = CK_SELSTOP;
            default: kind = CK_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/scsi_fe_irq_fsm.sv
module scsi_fe_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    input  logic kill,
    output logic irq
);
    import scsi_fe_pkg::*;

    irq_state_t state_q, state_d;

    // Next state: kill beats raise, raise beats ack.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (!kill && raise) state_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                if (kill)          state_d = IRQ_QUIET;
                else if (raise)    state_d = IRQ_RAISED;
                else if (ack)      state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // Output
    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/scsi_fe_action_out.sv
module scsi_fe_action_out (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fire,
    input  scsi_fe_pkg::cmd_kind_t kind,
    output logic                   xfer_start,
    output logic                   sel_atn,
    output logic                   sel_atn_stop,
    output logic                   resp_start
);
    import scsi_fe_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_start   <= 1'b0;
            sel_atn      <= 1'b0;
            sel_atn_stop <= 1'b0;
            resp_start   <= 1'b0;
        end else begin
            xfer_start   <= fire && (kind == CK_XFER);
            sel_atn      <= fire && (kind == CK_SELATN);
            sel_atn_stop <= fire && (kind == CK_SELSTOP);
            resp_start   <= fire && ((kind == CK_CMPLSEQ) || (kind == CK_MSGACC));
        end
    end
endmodule

// File: rtl/scsi_reg_front.sv
module scsi_reg_front #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dma_mode,
    output logic              xfer_start,
    output logic              sel_atn,
    output logic              sel_atn_stop,
    output logic              resp_start,
    input  logic              eng_report,
    input  logic [DATA_W-1:0] eng_status,
    input  logic [DATA_W-1:0] eng_intr,
    input  logic [DATA_W-1:0] eng_seq
);
    import scsi_fe_pkg::*;

    localparam int IDX_W = $clog2(NREG);

    localparam logic [IDX_W-1:0] I_TCLO = IDX_W'(SLOT_TC_LO);
    localparam logic [IDX_W-1:0] I_TCHI = IDX_W'(SLOT_TC_HI);
    localparam logic [IDX_W-1:0] I_CMD  = IDX_W'(SLOT_CMD);
    localparam logic [IDX_W-1:0] I_STAT = IDX_W'(SLOT_STAT);
    localparam logic [IDX_W-1:0] I_INTR = IDX_W'(SLOT_INTR);
    localparam logic [IDX_W-1:0] I_SEQ  = IDX_W'(SLOT_SEQ);
    localparam logic [IDX_W-1:0] I_CFG  = IDX_W'(SLOT_CFG);
    localparam logic [IDX_W-1:0] I_MSK  = IDX_W'(SLOT_MASKED);
    localparam logic [IDX_W-1:0] I_DIR  = IDX_W'(SLOT_DIR_LO);
    localparam logic [IDX_W-1:0] I_VAR  = IDX_W'(SLOT_VARIANT);

    localparam logic [DATA_W-1:0] D_VARIANT = DATA_W'(VARIANT_ID);
    localparam logic [DATA_W-1:0] D_MASK11  = DATA_W'(MASK_SLOT11);
    localparam logic [DATA_W-1:0] D_TC      = DATA_W'(STAT_TC);
    localparam logic [DATA_W-1:0] D_ACKCLR  = DATA_W'(STAT_ACK_CLR);
    localparam logic [DATA_W-1:0] D_FDONE   = DATA_W'(INTR_FUNC_DONE);
    localparam logic [DATA_W-1:0] D_DISC    = DATA_W'(INTR_DISCON);
    localparam logic [DATA_W-1:0] D_BRST    = DATA_W'(INTR_BUS_RST);

    // Register banks
    logic [DATA_W-1:0] rbank [NREG];
    logic [DATA_W-1:0] wbank [NREG];
    logic [DATA_W-1:0] rnext [NREG];
    logic [DATA_W-1:0] wnext [NREG];
    logic              dma_q, dma_next;

    // Decode
    logic [IDX_W-1:0] idx;
    cmd_kind_t        kind;
    logic             dma_sel;

    scsi_fe_addr_dec #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_adec (
        .addr (bus_addr),
        .idx  (idx)
    );

    scsi_fe_cmd_dec #(
        .DATA_W (DATA_W)
    ) u_cdec (
        .cmd     (bus_wdata),
        .kind    (kind),
        .dma_sel (dma_sel)
    );

    logic cmd_wr, intr_ack, chip_rst, brst_raise, irq_raise;

    always_comb begin
        cmd_wr     = bus_wr && (idx == I_CMD);
        intr_ack   = bus_rd && (idx == I_INTR);
        chip_rst   = cmd_wr && (kind == CK_CHIPRST);
        brst_raise = cmd_wr && (kind == CK_BUSRST) && !wbank[I_CFG][CFG_BRST_QUIET];
        irq_raise  = eng_report || brst_raise;
    end

    scsi_fe_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (irq_raise),
        .ack   (intr_ack),
        .kill  (chip_rst),
        .irq   (irq)
    );

    scsi_fe_action_out u_act (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (cmd_wr),
        .kind         (kind),
        .xfer_start   (xfer_start),
        .sel_atn      (sel_atn),
        .sel_atn_stop (sel_atn_stop),
        .resp_start   (resp_start)
    );

    // Next-state of both banks. Order of precedence within one cycle:
    // read acknowledge, CPU slot write, engine report, command effects.
    always_comb begin
        rnext    = rbank;
        wnext    = wbank;
        dma_next = dma_q;

        if (intr_ack) begin
            rnext[I_STAT] = rbank[I_STAT] & ~D_ACKCLR;
        end

        if (bus_wr) begin
            wnext[idx] = bus_wdata;
            if ((idx == I_TCLO) || (idx == I_TCHI)) begin
                rnext[I_STAT] = rnext[I_STAT] & ~D_TC;
            end else if ((idx == I_CFG) || (idx >= I_DIR)) begin
                rnext[idx] = bus_wdata;
            end else if (idx == I_MSK) begin
                rnext[idx] = bus_wdata & D_MASK11;
            end
        end

        if (eng_report) begin
            rnext[I_STAT] = eng_status;
            rnext[I_INTR] = eng_intr;
            rnext[I_SEQ]  = eng_seq;
        end

        if (cmd_wr) begin
            rnext[I_CMD] = bus_wdata;
            dma_next     = dma_sel;
            if (dma_sel) begin
                rnext[I_TCLO] = wbank[I_TCLO];
                rnext[I_TCHI] = wbank[I_TCHI];
            end
            unique case (kind)
                CK_FLUSH: begin
                    rnext[I_INTR] = D_FDONE;
                    rnext[I_SEQ]  = '0;
                end
                CK_BUSRST: begin
                    rnext[I_INTR] = D_BRST;
                end
                CK_MSGACC: begin
                    rnext[I_INTR] = D_DISC;
                    rnext[I_SEQ]  = '0;
                end
                CK_CHIPRST: begin
                    for (int i = 0; i < NREG; i++) begin
                        rnext[i] = '0;
                        wnext[i] = '0;
                    end
                    rnext[I_VAR] = D_VARIANT;
                    wnext[I_CMD] = bus_wdata;
                    dma_next     = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // Bank registers and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rbank[i] <= '0;
                wbank[i] <= '0;
            end
            rbank[I_VAR] <= D_VARIANT;
            dma_q        <= 1'b0;
            bus_rdata    <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                rbank[i] <= rnext[i];
                wbank[i] <= wnext[i];
            end
            dma_q <= dma_next;
            if (bus_rd) begin
                bus_rdata <= rbank[idx];
            end
        end
    end

    always_comb begin
        dma_mode = dma_q;
    end
endmodule

// File: rtl/scsi_reg_front_chk.sv
module scsi_reg_front_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              eng_report,
    input logic              irq,
    input logic              dma_mode,
    input logic              xfer_start,
    input logic              sel_atn,
    input logic              sel_atn_stop,
    input logic              resp_start
);
    localparam int IDX_W = $clog2(NREG);

    logic [IDX_W-1:0] c_idx;
    logic             c_cmd_wr;
    assign c_idx    = bus_addr[IDX_W+1:2];
    assign c_cmd_wr = bus_wr && (c_idx == IDX_W'(3));

    // R4: at most one action pulse in any cycle
    a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, sel_atn, sel_atn_stop, resp_start}));

    // R4: a transfer pulse follows a transfer command write
    a_r4_xfer_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd_wr && bus_wdata[6:0] == 7'h10) |=> xfer_start);

    // R4: a pulse never lasts two clocks
    a_r4_sel_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        sel_atn |=> !sel_atn);

    // R3: bit 7 of a non-reset command selects the mode
    a_r3_dma_follows_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd_wr && bus_wdata[6:0] != 7'h02) |=> (dma_mode == $past(bus_wdata[7])));

    // R8: interrupt acknowledge with no new cause drops irq
    a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && c_idx == IDX_W'(5) && !eng_report && !bus_wr) |=> !irq);

    // R12: a report raises irq unless a chip reset lands with it
    a_r12_report_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_report && !(c_cmd_wr && bus_wdata[6:0] == 7'h02)) |=> irq);

    // R11: chip reset leaves irq and DMA mode low
    a_r11_chip_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd_wr && bus_wdata[6:0] == 7'h02) |=> (!irq && !dma_mode));
endmodule

bind scsi_reg_front scsi_reg_front_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NREG   (NREG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .eng_report   (eng_report),
    .irq          (irq),
    .dma_mode     (dma_mode),
    .xfer_start   (xfer_start),
    .sel_atn      (sel_atn),
    .sel_atn_stop (sel_atn_stop),
    .resp_start   (resp_start)
);

// File: tb/scsi_reg_front_bench.sv
`timescale 1ns/1ps
module scsi_reg_front_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, dma_mode, xfer_start, sel_atn, sel_atn_stop, resp_start;
    logic       eng_report = 1'b0;
    logic [7:0] eng_status = '0, eng_intr = '0, eng_seq = '0;

    always #10 clk = ~clk;

    scsi_reg_front u_scsi_reg_front (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq (irq), .dma_mode (dma_mode),
        .xfer_start (xfer_start), .sel_atn (sel_atn),
        .sel_atn_stop (sel_atn_stop), .resp_start (resp_start),
        .eng_report (eng_report), .eng_status (eng_status),
        .eng_intr (eng_intr), .eng_seq (eng_seq)
    );

    // Behavioural reference state
    int m_rd[16];
    int m_wr[16];
    int m_irq, m_dma, m_rdata;
    int m_px, m_ps, m_pst, m_pr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_rd[i] = 0;
            m_wr[i] = 0;
        end
        m_rd[14] = 4;
        m_irq = 0; m_dma = 0; m_rdata = 0;
        m_px = 0; m_ps = 0; m_pst = 0; m_pr = 0;
    endtask

    task automatic cmp(input int act, input int exp, input string what, input string tag);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive, update the reference at the edge, compare after it.
    task automatic step(input bit we, input bit re, input int a, input int d,
                        input bit ev, input int es, input int ei, input int eq,
                        input string tag);
        int nr[16];
        int nw[16];
        int nirq, ndma, idx, code;
        bus_wr = we; bus_rd = re; bus_addr = a[7:0]; bus_wdata = d[7:0];
        eng_report = ev; eng_status = es[7:0]; eng_intr = ei[7:0]; eng_seq = eq[7:0];
        @(posedge clk);
        idx = (a & 8'h3F) >> 2;
        nr = m_rd; nw = m_wr; nirq = m_irq; ndma = m_dma;
        m_px = 0; m_ps = 0; m_pst = 0; m_pr = 0;
        if (re) begin
            m_rdata = m_rd[idx];
            if (idx == 5) begin
                nr[4] = nr[4] & 8'h1F;
                nirq = 0;
            end
        end
        if (we) begin
            nw[idx] = d;
            if (idx == 0 || idx == 1) nr[4] = nr[4] & 8'hEF;
            else if (idx == 8 || idx >= 12) nr[idx] = d;
            else if (idx == 11) nr[idx] = d & 8'h15;
        end
        if (ev) begin
            nr[4] = es; nr[5] = ei; nr[6] = eq; nirq = 1;
        end
        if (we && idx == 3) begin
            code = d & 8'h7F;
            nr[3] = d;
            if (d & 8'h80) begin
                ndma = 1; nr[0] = m_wr[0]; nr[1] = m_wr[1];
            end else begin
                ndma = 0;
            end
            case (code)
                8'h01: begin nr[5] = 8'h08; nr[6] = 0; end
                8'h02: begin
                    for (int i = 0; i < 16; i++) begin nr[i] = 0; nw[i] = 0; end
                    nr[14] = 4; nw[3] = d; ndma = 0; nirq = 0;
                end
                8'h03: begin
                    nr[5] = 8'h80;
                    if ((m_wr[8] & 8'h40) == 0) nirq = 1;
                end
                8'h10: m_px = 1;
                8'h11: m_pr = 1;
                8'h12: begin m_pr = 1; nr[5] = 8'h20; nr[6] = 0; end
                8'h42: m_ps = 1;
                8'h43: m_pst = 1;
                default: ;
            endcase
        end
        m_rd = nr; m_wr = nw; m_irq = nirq; m_dma = ndma;
        @(negedge clk);
        vectors++;
        cmp(bus_rdata, m_rdata, "rdata", tag);
        cmp(irq, m_irq, "irq", tag);
        cmp(dma_mode, m_dma, "dma_mode", tag);
        cmp(xfer_start, m_px, "xfer_start", tag);
        cmp(sel_atn, m_ps, "sel_atn", tag);
        cmp(sel_atn_stop, m_pst, "sel_atn_stop", tag);
        cmp(resp_start, m_pr, "resp_start", tag);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(1, 0, a, d, 0, 0, 0, 0, tag);
    endtask
    task automatic rd(input int a, input string tag);
        step(0, 1, a, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic report(input int es, input int ei, input int eq, input string tag);
        step(0, 0, 0, 0, 1, es, ei, eq, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset contents of every readable slot
        for (int i = 0; i < 16; i++) rd(i * 4, "R2");
        rd(0, "R2");

        // R1: address aliasing on four-byte strides
        rd(8'h78, "R1");
        rd(8'hBB, "R1");
        rd(8'h15, "R1");

        // R10: storage rules per slot
        wr(8'h20, 8'h3C, "R10");
        wr(8'h2C, 8'hFF, "R10");
        for (int i = 12; i < 16; i++) wr(i * 4, 8'hA0 + i, "R10");
        wr(8'h08, 8'h5A, "R10");
        for (int i = 4; i < 8; i++) wr(i * 4, 8'h5A, "R10");
        wr(8'h24, 8'h5A, "R10");
        wr(8'h28, 8'h5A, "R10");
        for (int i = 0; i < 16; i++) rd(i * 4, "R10");

        // R3: count bytes, PIO command then DMA command
        wr(8'h00, 8'h34, "R3");
        wr(8'h04, 8'h12, "R3");
        wr(8'h0C, 8'h00, "R3");
        rd(8'h00, "R3");
        wr(8'h0C, 8'h80, "R3");
        rd(8'h00, "R3");
        rd(8'h04, "R3");
        rd(8'h0C, "R3");
        wr(8'h0C, 8'h00, "R3");

        // R4: action pulses
        wr(8'h0C, 8'h10, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
        wr(8'h0C, 8'h42, "R4");
        wr(8'h0C, 8'hC3, "R4");
        wr(8'h0C, 8'h11, "R4");
        wr(8'h0C, 8'h90, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R4");

        // R5: flush
        report(8'h00, 8'h55, 8'h07, "R5");
        wr(8'h0C, 8'h01, "R5");
        rd(8'h14, "R5");
        rd(8'h18, "R5");

        // R12 and R8: report, then acknowledge
        report(8'hF3, 8'h18, 8'h04, "R12");
        rd(8'h10, "R12");
        rd(8'h18, "R12");
        rd(8'h14, "R8");
        rd(8'h10, "R8");
        rd(8'h14, "R8");

        // R9: count writes clear terminal count only
        wr(8'h00, 8'h77, "R9");
        rd(8'h10, "R9");
        rd(8'h00, "R9");
        report(8'h1F, 8'h00, 8'h00, "R9");
        wr(8'h04, 8'h66, "R9");
        rd(8'h10, "R9");
        rd(8'h14, "R9");

        // R7: bus reset, masked then unmasked
        wr(8'h20, 8'h40, "R7");
        wr(8'h0C, 8'h03, "R7");
        rd(8'h14, "R7");
        wr(8'h20, 8'hBF, "R7");
        wr(8'h0C, 8'h03, "R7");
        rd(8'h14, "R7");
        wr(8'h0C, 8'h03, "R7");
        step(0, 1, 8'h14, 0, 0, 0, 0, 0, "R7");

        // R6: message accepted
        report(8'h00, 8'h11, 8'h04, "R6");
        wr(8'h0C, 8'h12, "R6");
        rd(8'h14, "R6");
        rd(8'h18, "R6");

        // R13: unknown codes
        wr(8'h0C, 8'h1A, "R13");
        wr(8'h0C, 8'hFE, "R13");
        rd(8'h0C, "R13");
        rd(8'h14, "R13");
        rd(8'h18, "R13");

        // R12: report colliding with acknowledge and with count write
        report(8'hE0, 8'h01, 8'h02, "R12");
        step(0, 1, 8'h14, 0, 1, 8'hF0, 8'h08, 8'h04, "R12");
        rd(8'h10, "R12");
        rd(8'h14, "R12");
        step(1, 0, 8'h00, 8'h99, 1, 8'h10, 8'h02, 8'h01, "R12");
        rd(8'h10, "R12");

        // R11: chip reset, with DMA bit and pending irq
        wr(8'h00, 8'h21, "R11");
        wr(8'h0C, 8'h80, "R11");
        report(8'hFF, 8'hFF, 8'hFF, "R11");
        wr(8'h0C, 8'h82, "R11");
        for (int i = 0; i < 16; i++) rd(i * 4, "R11");
        wr(8'h0C, 8'h80, "R11");
        rd(8'h00, "R11");
        rd(8'h04, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");

        finish_run();
    end

endmodule